// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Combiner

This block gathers the events of an SPI peripheral and turns them into one packed 14-bit status word and a single interrupt line. The peripheral has a four-entry receive queue and a four-entry transmit queue. The block does not hold the queues. It tracks how full each one is from push and pop strobes. It also watches:

- transfer-start requests,
- bit and byte completion strobes from the shift engine,
- the chip-select line,
- a set of static configuration inputs.

Software reads the status word through a read strobe. That read clears every sticky flag. The occupancy fields and the excess bit are live values, so a read does not change them.

A small state machine follows chip-select. Its states are:

- `CS_IDLE`: chip-select is high.
- `CS_SEL`: chip-select is low and no byte is in progress.
- `CS_SHIFT`: a byte is part-way through shifting.

Its transitions are:

- `CS_IDLE`→`CS_SEL` on a low chip-select. This is the falling edge.
- `CS_SEL`→`CS_SHIFT` on a bit tick that does not finish the byte.
- `CS_SHIFT`→`CS_SEL` on a byte-done strobe.
- `CS_SEL`→`CS_IDLE` on a high chip-select.
- `CS_SHIFT`→`CS_IDLE` on a high chip-select. This is an abort unless a byte completes in the same cycle.

Top module: `spi_stat_irq`

## Requirements
- R1: Each occupancy field (`stat_data[10:8]` for receive, `stat_data[3:1]` for transmit) is a binary count from 0 to 4. A push raises it by one. A pop lowers it by one. A push and a pop in the same cycle leave it unchanged. A pop while empty is ignored. A push while full (without a pop) is dropped.
- R2: A receive push while the receive count is 4 and there is no receive pop sets the overflow flag, `stat_data[7]`. The count stays at 4.
- R3: `xfer_start` while the transmit count is 0 sets the underflow flag, `stat_data[4]`. `xfer_start` with a nonzero count does not set it.
- R4: With `cfg_rx_flush` set, an overflow still sets `stat_data[7]` but does not assert `irq` or `stat_data[0]`. `cfg_tx_flush` does the same for underflow.
- R5: With `cfg_tx_mode`=0, `stat_data[6]` sets on the N-th `rx_done` strobe, where N = `cfg_count`+1. `tx_done` strobes do not count. The byte counter restarts after each hit and whenever the mode bit changes.
- R6: With `cfg_tx_mode`=1, `stat_data[5]` sets on the N-th `tx_done` strobe. `rx_done` strobes do not count.
- R7: If chip-select rises while a byte is part-shifted (a `bit_tick` was seen after the last byte completion) and no byte completes in that cycle, `stat_data[12]` sets and `irq` asserts.
- R8: A chip-select falling edge sets `stat_data[13]` and asserts `irq` only when `cfg_master`, `cfg_cont`, `cfg_hispeed` and `cfg_csfall_en` are all 1.
- R9: `stat_data[11]` is live and not sticky. It is 1 exactly while the receive count exceeds `cfg_count`+1.
- R10: A cycle with `stat_rd` high returns the flags as they were before the read. It then clears bits 13, 12, 7, 6, 5, 4 and 0. Bits 11, 10:8 and 3:1 are unaffected.
- R11: A set event that coincides with a status read wins. The flag is 1 after that cycle.
- R12: `irq` is the OR of the sticky flags whose interrupt is enabled. `stat_data[0]` sets whenever such an enabled event occurs. Both stay high until a read.
- R13: After reset, `stat_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Byte written into receive queue |
| rx_pop | input | 1 | Byte read from receive queue |
| tx_push | input | 1 | Byte written into transmit queue |
| tx_pop | input | 1 | Byte taken from transmit queue |
| xfer_start | input | 1 | Shift engine starts a transfer |
| bit_tick | input | 1 | A bit of the current byte was shifted |
| rx_done | input | 1 | A full byte was received |
| tx_done | input | 1 | A full byte was transmitted |
| cs_n | input | 1 | Chip-select, active low |
| cfg_tx_mode | input | 1 | 0: count received bytes, 1: count transmitted bytes |
| cfg_count | input | 2 | Byte threshold minus one, also the excess watermark |
| cfg_rx_flush | input | 1 | Masks the overflow interrupt |
| cfg_tx_flush | input | 1 | Masks the underflow interrupt |
| cfg_master | input | 1 | Master mode |
| cfg_cont | input | 1 | Continuous transfer mode |
| cfg_hispeed | input | 1 | High-frequency mode |
| cfg_csfall_en | input | 1 | Chip-select falling-edge interrupt enable |
| stat_rd | input | 1 | Status read strobe |
| stat_data | output | 14 | Packed status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a chip-select abort: the state machine must be in `CS_SHIFT` when chip-select rises. The stimulus drops chip-select, gives one `bit_tick` with no byte-done, and then raises chip-select. A second sequence ends the byte with `rx_done` before releasing chip-select and must not flag an error.

Overflow that coincides with a status read is also reached deliberately. The receive queue is filled to four. The fifth push is issued in the same cycle as `stat_rd`. The returned word must show the old flag and the following cycle the set flag.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_SEL   = 2'd1,
        CS_SHIFT = 2'd2
    } cs_state_t;

    typedef struct packed {
        logic cs_fall;
        logic cs_abort;
        logic rx_ovf;
        logic rx_hit;
        logic tx_hit;
        logic tx_unf;
        logic any;
    } sticky_t;
endpackage

// File: rtl/spi_stat_level.sv
module spi_stat_level #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          over
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic eff_pop, eff_push, full;

    always_comb begin
        full     = (level == FULL);
        empty    = (level == '0);
        eff_pop  = pop && !empty;
        eff_push = push && (!full || eff_pop);
        over     = push && full && !pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level <= '0;
        else if (eff_push && !eff_pop)
            level <= level + 1'b1;
        else if (eff_pop && !eff_push)
            level <= level - 1'b1;
    end

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL); // R1
    AST_OVER_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> level == FULL); // R2
endmodule

// File: rtl/spi_stat_bytecnt.sv
module spi_stat_bytecnt #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          rx_strobe,
    input  logic          tx_strobe,
    input  logic [NW-1:0] thresh_m1,
    output logic          hit
);
    logic [CW-1:0] cnt;
    logic          mode_q;
    logic          strobe;
    logic [CW-1:0] target;

    always_comb begin
        strobe = mode ? tx_strobe : rx_strobe;
        target = CW'(thresh_m1) + 1'b1;
        hit    = strobe && (mode == mode_q) && (cnt + 1'b1 == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode;
            if (mode != mode_q || hit)
                cnt <= '0;
            else if (strobe)
                cnt <= cnt + 1'b1;
        end
    end

    AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cnt == '0); // R5
endmodule

// File: rtl/spi_stat_csmon.sv
module spi_stat_csmon
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic bit_tick,
    input  logic byte_end,
    output logic fall_evt,
    output logic abort_evt
);
    cs_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        fall_evt  = 1'b0;
        abort_evt = 1'b0;
        unique case (state)
            CS_IDLE: begin
                if (!cs_n) begin
                    nxt      = CS_SEL;
                    fall_evt = 1'b1;
                end
            end
            CS_SEL: begin
                if (cs_n)
                    nxt = CS_IDLE;
                else if (bit_tick && !byte_end)
                    nxt = CS_SHIFT;
            end
            CS_SHIFT: begin
                if (cs_n) begin
                    nxt       = CS_IDLE;
                    abort_evt = !byte_end;
                end else if (byte_end)
                    nxt = CS_SEL;
            end
            default: nxt = CS_IDLE;
        endcase
    end

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> state == CS_IDLE); // R7
    AST_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> state != CS_IDLE); // R8
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_stat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(DEPTH),
    localparam int SW = 2 * CW + 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          xfer_start,
    input  logic          bit_tick,
    input  logic          rx_done,
    input  logic          tx_done,
    input  logic          cs_n,
    input  logic          cfg_tx_mode,
    input  logic [NW-1:0] cfg_count,
    input  logic          cfg_rx_flush,
    input  logic          cfg_tx_flush,
    input  logic          cfg_master,
    input  logic          cfg_cont,
    input  logic          cfg_hispeed,
    input  logic          cfg_csfall_en,
    input  logic          stat_rd,
    output logic [SW-1:0] stat_data,
    output logic          irq
);
    logic [CW-1:0] rx_lvl, tx_lvl;
    logic          rx_empty, tx_empty, rx_over, tx_over;
    logic          hit, fall_evt, abort_evt, excess;
    sticky_t       flags, set;

    spi_stat_level #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .level(rx_lvl), .empty(rx_empty), .over(rx_over)
    );

    spi_stat_level #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .level(tx_lvl), .empty(tx_empty), .over(tx_over)
    );

    spi_stat_bytecnt #(.DEPTH(DEPTH)) u_bytes (
        .clk(clk), .rst_n(rst_n), .mode(cfg_tx_mode),
        .rx_strobe(rx_done), .tx_strobe(tx_done),
        .thresh_m1(cfg_count), .hit(hit)
    );

    spi_stat_csmon u_cs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_tick(bit_tick),
        .byte_end(rx_done | tx_done),
        .fall_evt(fall_evt), .abort_evt(abort_evt)
    );

    always_comb begin
        set          = '0;
        set.cs_fall  = fall_evt && cfg_master && cfg_cont && cfg_hispeed && cfg_csfall_en;
        set.cs_abort = abort_evt;
        set.rx_ovf   = rx_over;
        set.tx_unf   = xfer_start && tx_empty;
        set.rx_hit   = hit && !cfg_tx_mode;
        set.tx_hit   = hit && cfg_tx_mode;
        set.any      = set.cs_fall | set.cs_abort | set.rx_hit | set.tx_hit
                     | (set.rx_ovf && !cfg_rx_flush) | (set.tx_unf && !cfg_tx_flush);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (stat_rd ? '0 : flags) | set;
    end

    always_comb begin
        excess    = rx_lvl > (CW'(cfg_count) + 1'b1);
        irq       = flags.cs_fall | flags.cs_abort | flags.rx_hit | flags.tx_hit
                  | (flags.rx_ovf && !cfg_rx_flush) | (flags.tx_unf && !cfg_tx_flush);
        stat_data = {flags.cs_fall, flags.cs_abort, excess, rx_lvl,
                     flags.rx_ovf, flags.rx_hit, flags.tx_hit, flags.tx_unf,
                     tx_lvl, flags.any};
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && set == '0 |=> flags == '0); // R10
    AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        set.rx_ovf |=> flags.rx_ovf); // R11
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !stat_rd && $stable(cfg_rx_flush) && $stable(cfg_tx_flush) |=> irq); // R12
    AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.tx_unf) |-> $past(tx_empty)); // R3
endmodule

// File: tb/tb_spi_stat_irq.sv
module tb_spi_stat_irq;
    logic clk = 0, rst_n = 0;
    logic rx_push, rx_pop, tx_push, tx_pop, xfer_start, bit_tick, rx_done, tx_done;
    logic cs_n, cfg_tx_mode, cfg_rx_flush, cfg_tx_flush, cfg_master, cfg_cont;
    logic cfg_hispeed, cfg_csfall_en, stat_rd, irq;
    logic [1:0] cfg_count;
    logic [13:0] stat_data;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    spi_stat_irq dut (.*);

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        {rx_push, rx_pop, tx_push, tx_pop, xfer_start, bit_tick, rx_done, tx_done} = '0;
        stat_rd = 0;
    endtask

    task automatic do_reset();
        clear_in();
        cs_n = 1; cfg_tx_mode = 0; cfg_count = 2'd3; cfg_rx_flush = 0; cfg_tx_flush = 0;
        {cfg_master, cfg_cont, cfg_hispeed, cfg_csfall_en} = '0;
        rst_n = 0; step(); step(); rst_n = 1; step();
    endtask

    task automatic read_status(output logic [13:0] v);
        stat_rd = 1; #1; v = stat_data; step(); stat_rd = 0;
    endtask

    task automatic rx_pushes(int n);
        for (int i = 0; i < n; i++) begin rx_push = 1; step(); rx_push = 0; end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R13 status", stat_data, 0);
        chk("R13 irq", irq, 0);
    endtask

    task automatic t_levels();
        do_reset();
        rx_pushes(3);
        chk("R1 rx level 3", stat_data[10:8], 3);
        rx_push = 1; rx_pop = 1; step(); clear_in();
        chk("R1 push+pop same", stat_data[10:8], 3);
        rx_pop = 1; step(); step(); step(); step(); clear_in();
        chk("R1 pop to empty ignored", stat_data[10:8], 0);
        tx_push = 1; step(); step(); step(); step(); step(); clear_in();
        chk("R1 tx level capped", stat_data[3:1], 4);
        chk("R1 no flags", stat_data[13:11], 0);
    endtask

    task automatic t_overflow();
        logic [13:0] v;
        do_reset();
        cfg_count = 2'd1;
        rx_pushes(4);
        chk("R9 excess at 4 > 2", stat_data[11], 1);
        chk("R2 no ovf at fill", stat_data[7], 0);
        rx_pushes(1);
        chk("R2 ovf set", stat_data[7], 1);
        chk("R2 level stays 4", stat_data[10:8], 4);
        chk("R12 irq", irq, 1);
        chk("R12 any bit", stat_data[0], 1);
        read_status(v);
        chk("R10 read returns old", v[7], 1);
        chk("R10 cleared", stat_data[7], 0);
        chk("R10 any cleared", stat_data[0], 0);
        chk("R10 irq drops", irq, 0);
        chk("R10 level kept", stat_data[10:8], 4);
        chk("R10 excess kept", stat_data[11], 1);
        rx_pop = 1; step(); step(); rx_pop = 0;
        chk("R9 excess off at 2", stat_data[11], 0);
    endtask

    task automatic t_flush();
        do_reset();
        cfg_rx_flush = 1; cfg_tx_flush = 1;
        rx_pushes(5);
        chk("R4 ovf flag still set", stat_data[7], 1);
        xfer_start = 1; step(); xfer_start = 0;
        chk("R4 unf flag still set", stat_data[4], 1);
        chk("R4 irq masked", irq, 0);
        chk("R4 any not set", stat_data[0], 0);
    endtask

    task automatic t_underflow();
        logic [13:0] v;
        do_reset();
        xfer_start = 1; step(); xfer_start = 0;
        chk("R3 unf on empty", stat_data[4], 1);
        chk("R3 irq", irq, 1);
        read_status(v);
        tx_push = 1; step(); tx_push = 0;
        xfer_start = 1; step(); xfer_start = 0;
        chk("R3 no unf with data", stat_data[4], 0);
        step(); step();
        chk("R12 irq stays low", irq, 0);
    endtask

    task automatic t_rxirq();
        do_reset();
        cfg_count = 2'd2;
        step();
        rx_done = 1; step(); step(); rx_done = 0;
        tx_done = 1; step(); step(); step(); tx_done = 0;
        chk("R5 not yet", stat_data[6:5], 0);
        rx_done = 1; step(); rx_done = 0;
        chk("R5 rx hit after 3", stat_data[6:5], 2'b10);
        chk("R5 irq", irq, 1);
    endtask

    task automatic t_txirq();
        logic [13:0] v;
        do_reset();
        cfg_count = 2'd1; cfg_tx_mode = 1; step();
        rx_done = 1; step(); step(); rx_done = 0;
        tx_done = 1; step(); tx_done = 0;
        chk("R6 not after 1", stat_data[6:5], 0);
        tx_done = 1; step(); tx_done = 0;
        chk("R6 tx hit after 2", stat_data[6:5], 2'b01);
        read_status(v);
        tx_done = 1; step(); tx_done = 0;
        chk("R6 counter restarted", stat_data[5], 0);
    endtask

    task automatic t_cs();
        logic [13:0] v;
        do_reset();
        cs_n = 0; step();
        chk("R8 no fall flag when disabled", stat_data[13], 0);
        bit_tick = 1; step(); bit_tick = 0;
        cs_n = 1; step();
        chk("R7 abort flag", stat_data[12], 1);
        chk("R7 irq", irq, 1);
        read_status(v);
        cs_n = 0; step();
        bit_tick = 1; step(); bit_tick = 0;
        rx_done = 1; step(); rx_done = 0;
        cs_n = 1; step();
        chk("R7 clean byte no abort", stat_data[12], 0);
        {cfg_master, cfg_cont, cfg_hispeed, cfg_csfall_en} = 4'b1111;
        cs_n = 0; step();
        chk("R8 fall flag", stat_data[13], 1);
        chk("R8 irq", irq, 1);
        read_status(v);
        cs_n = 1; step(); cfg_hispeed = 0;
        cs_n = 0; step();
        chk("R8 gated by mode", stat_data[13], 0);
    endtask

    task automatic t_setwins();
        logic [13:0] v;
        do_reset();
        rx_pushes(4);
        rx_push = 1; read_status(v); rx_push = 0;
        chk("R11 read sees old", v[7], 0);
        chk("R11 set wins", stat_data[7], 1);
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_levels();
        t_overflow();
        t_flush();
        t_underflow();
        t_rxirq();
        t_txirq();
        t_cs();
        t_setwins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule